// File: doc/BRIEF.md
# Half-Word to Word Register Bridge

The bridge lets a master with a 16-bit data path reach a register file organised as 32-bit words. Each word is reached with two half-word transfers, and address bit 1 picks the half. A write to the low half is only held inside the bridge. The write to the high half then commits the full word downstream in one access, which combines the new upper data with the held lower data.

Reads go the opposite way. A read of the low half performs the single downstream word read, returns the lower 16 bits and snapshots the upper 16 bits. The next read of the high half returns that snapshot and does not touch the register file. Both halves therefore come from one access, even when the register changes on its own, such as a free-running counter. A register with read side effects sees exactly one read per low-half read.

The downstream port is single-cycle. Strobes, address and write data are driven combinationally from the request, and read data is returned in the same cycle. Every request gets a registered response one cycle later. Any transfer size other than half-word is refused with an error flag and zero data.

Top module: `hw_word_bridge`

## Requirements
- R1: After reset, `rsp_valid_o`, `reg_we_o` and `reg_re_o` are low, and both holding registers (write low half, read high half) are zero.
- R2: A half-word write (`req_size_i` = 2'b01) with address bit 1 clear only stores `req_wdata_i` in the write holding register and issues no downstream access.
- R3: A half-word write with address bit 1 set issues exactly one downstream write with `req_wdata_i` in bits 31:16 and the write holding register in bits 15:0.
- R4: A half-word read with address bit 1 clear issues exactly one downstream read, returns its bits 15:0 and stores its bits 31:16 in the read holding register.
- R5: A half-word read with address bit 1 set returns the read holding register and issues no downstream access, even if the downstream word has changed since the low-half read.
- R6: The downstream word address is the request address with bit 1 forced to zero; a downstream write and a downstream read never occur in the same cycle.
- R7: A request with `req_size_i` other than 2'b01 gives `rsp_err_o` = 1 with `rsp_rdata_o` = 0, issues no downstream access and leaves both holding registers unchanged.
- R8: Every accepted request gives exactly one `rsp_valid_o` pulse in the following cycle; write responses carry zero data and no error.
- R9: A high-half write with no earlier low-half write uses the last held value, which is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Transfer size; 2'b01 = half-word, any other value is refused |
| req_addr_i | input | ADDR_W | Byte address; bit 1 selects the upper half |
| req_wdata_i | input | HALF_W | Half-word write data |
| rsp_valid_o | output | 1 | Response pulse, one cycle after the request |
| rsp_rdata_o | output | HALF_W | Half-word read data |
| rsp_err_o | output | 1 | Request was refused |
| reg_we_o | output | 1 | Downstream word write strobe |
| reg_re_o | output | 1 | Downstream word read strobe |
| reg_addr_o | output | ADDR_W | Downstream word address |
| reg_wdata_o | output | 2*HALF_W | Downstream write word |
| reg_rdata_i | input | 2*HALF_W | Downstream read word, valid in the strobe cycle |

## Verification
The hardest case to bring about is a register whose upper half changes between the two halves of a read. Only then does the snapshot differ from a second live read. The bench models a counter at one downstream address. The counter is preset just below a carry into bit 16 and increments on every downstream read. A correct bridge then returns the pre-carry upper half, and the bench checks that the read count rose by exactly one. Byte-size requests are placed between a held low half and its high-half commit, so that any disturbance of the holding register shows up in the committed word.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  localparam logic [1:0] SIZE_HALF = 2'b01;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_BAD,
    OP_WR_LO,
    OP_WR_HI,
    OP_RD_LO,
    OP_RD_HI
  } hwb_op_e;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
  import hwb_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [1:0] size_i,
  input  logic       upper_i,
  output hwb_op_e    op_o
);
  always_comb begin
    op_o = OP_IDLE;
    if (valid_i) begin
      if (size_i != SIZE_HALF) op_o = OP_BAD;
      else if (write_i)        op_o = upper_i ? OP_WR_HI : OP_WR_LO;
      else                     op_o = upper_i ? OP_RD_HI : OP_RD_LO;
    end
  end
endmodule

// File: rtl/hwb_hold.sv
module hwb_hold #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              rd_lo_i,
  input  logic [HALF_W-1:0] rd_upper_i,
  output logic [HALF_W-1:0] wr_hold_o,
  output logic [HALF_W-1:0] rd_hold_o
);
  logic [HALF_W-1:0] wr_hold_q, rd_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_hold_q <= '0;
      rd_hold_q <= '0;
    end else begin
      if (wr_lo_i) wr_hold_q <= wr_data_i;
      if (rd_lo_i) rd_hold_q <= rd_upper_i;
    end
  end

  assign wr_hold_o = wr_hold_q;
  assign rd_hold_o = rd_hold_q;

  // R2
  wr_hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> $stable(wr_hold_q));
  // R5
  rd_hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i |=> $stable(rd_hold_q));
endmodule

// File: rtl/hwb_rsp.sv
module hwb_rsp #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [HALF_W-1:0] data_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [HALF_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & err_i;
      data_o  <= valid_i ? data_i : '0;
    end
  end

  // R8
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> data_o == '0);
endmodule

// File: rtl/hw_word_bridge.sv
module hw_word_bridge
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [1:0]          req_size_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [HALF_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [HALF_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  output logic                reg_we_o,
  output logic                reg_re_o,
  output logic [ADDR_W-1:0]   reg_addr_o,
  output logic [2*HALF_W-1:0] reg_wdata_o,
  input  logic [2*HALF_W-1:0] reg_rdata_i
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] UPPER_SEL = ADDR_W'(2);

  hwb_op_e           op;
  logic [HALF_W-1:0] wr_hold, rd_hold, rsp_data;

  hwb_decode u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .size_i  (req_size_i),
    .upper_i (req_addr_i[1]),
    .op_o    (op)
  );

  hwb_hold #(.HALF_W(HALF_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (op == OP_WR_LO),
    .wr_data_i  (req_wdata_i),
    .rd_lo_i    (op == OP_RD_LO),
    .rd_upper_i (reg_rdata_i[WORD_W-1:HALF_W]),
    .wr_hold_o  (wr_hold),
    .rd_hold_o  (rd_hold)
  );

  assign reg_we_o    = (op == OP_WR_HI);
  assign reg_re_o    = (op == OP_RD_LO);
  assign reg_addr_o  = req_addr_i & ~UPPER_SEL;
  assign reg_wdata_o = {req_wdata_i, wr_hold};

  always_comb begin
    case (op)
      OP_RD_LO: rsp_data = reg_rdata_i[HALF_W-1:0];
      OP_RD_HI: rsp_data = rd_hold;
      default:  rsp_data = '0;
    endcase
  end

  hwb_rsp #(.HALF_W(HALF_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .err_i   (op == OP_BAD),
    .data_i  (rsp_data),
    .valid_o (rsp_valid_o),
    .err_o   (rsp_err_o),
    .data_o  (rsp_rdata_o)
  );

  // R6
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o}));
  // R6
  word_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> !reg_addr_o[1]);
  // R5
  hi_read_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RD_HI) |=> rsp_rdata_o == $past(rd_hold));
  // R7
  bad_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != SIZE_HALF) |-> !(reg_we_o || reg_re_o));
endmodule

// File: tb/hw_word_bridge_tb.sv
module hw_word_bridge_tb;
  localparam int ADDR_W = 8;
  localparam int HALF_W = 16;
  localparam logic [7:0] CTR_ADDR = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b01;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, reg_we, reg_re;
  logic [15:0] rsp_rdata;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  hw_word_bridge #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  // downstream model: 16 words plus a counter that advances on each read
  logic [31:0] mem [16];
  logic [31:0] ctr = '0;
  int wr_cnt = 0, rd_cnt = 0, addr_bad = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  assign reg_rdata = (reg_addr == CTR_ADDR) ? ctr : mem[reg_addr[5:2]];

  always @(posedge clk) begin
    if (reg_we) begin
      wr_cnt <= wr_cnt + 1;
      if (reg_addr != CTR_ADDR) mem[reg_addr[5:2]] <= reg_wdata;
    end
    if (reg_re) begin
      rd_cnt <= rd_cnt + 1;
      if (reg_addr == CTR_ADDR) ctr <= ctr + 1;
    end
    if ((reg_we || reg_re) && reg_addr[1]) addr_bad <= addr_bad + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                      input logic [15:0] wd, output logic [15:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 rsp_valid", 32'(rsp_valid), 32'h1);
    rd = rsp_rdata;
    er = rsp_err;
    @(negedge clk);
    chk("R8 single pulse", 32'(rsp_valid), 32'h0);
  endtask

  function automatic logic [15:0] lo_pat(int i);
    return 16'(i * 16'h1111) ^ 16'hA5A5;
  endfunction
  function automatic logic [15:0] hi_pat(int i);
    return 16'(i * 16'h0107) + 16'h3C00;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog expired: actual hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic er;
    int wbase, rbase;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R1 we/re", {30'b0, reg_we, reg_re}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(1'b0, 2'b01, 8'h02, 16'h0, rd, er);
    chk("R1 read hold zero", 32'(rd), 32'h0);

    // R9: high write straight after reset
    xfer(1'b1, 2'b01, 8'h06, 16'hBEEF, rd, er);
    chk("R8 write rsp data", {15'b0, er, rd}, 32'h0);
    chk("R9 word", mem[1], 32'hBEEF_0000);
    xfer(1'b1, 2'b01, 8'h0A, 16'h1234, rd, er);
    chk("R9 repeat hold", mem[2], 32'h1234_0000);

    // R2, R3: sweep all words
    for (int i = 0; i < 16; i++) begin
      wbase = wr_cnt; rbase = rd_cnt;
      xfer(1'b1, 2'b01, 8'(i * 4), lo_pat(i), rd, er);
      chk("R2 no downstream on low write", wr_cnt - wbase + rd_cnt - rbase, 0);
      xfer(1'b1, 2'b01, 8'(i * 4 + 2), hi_pat(i), rd, er);
      chk("R3 one write", wr_cnt - wbase, 1);
      chk("R3 word", mem[i], {hi_pat(i), lo_pat(i)});
    end

    // R4, R5: read back all words
    for (int i = 0; i < 16; i++) begin
      rbase = rd_cnt;
      xfer(1'b0, 2'b01, 8'(i * 4), 16'h0, rd, er);
      chk("R4 low half", 32'(rd), 32'(lo_pat(i)));
      chk("R4 one read", rd_cnt - rbase, 1);
      xfer(1'b0, 2'b01, 8'(i * 4 + 2), 16'h0, rd, er);
      chk("R5 high half", 32'(rd), 32'(hi_pat(i)));
      chk("R5 no read", rd_cnt - rbase, 1);
    end

    // R5: counter carries into upper half between the two halves
    @(negedge clk);
    ctr = 32'h0002_FFFF;
    rbase = rd_cnt;
    xfer(1'b0, 2'b01, CTR_ADDR, 16'h0, rd, er);
    chk("R4 counter low", 32'(rd), 32'hFFFF);
    chk("R4 counter read once", rd_cnt - rbase, 1);
    xfer(1'b0, 2'b01, CTR_ADDR | 8'h02, 16'h0, rd, er);
    chk("R5 counter snapshot", 32'(rd), 32'h0002);
    chk("R5 counter untouched", ctr, 32'h0003_0000);

    // R7: refused sizes between low hold and high commit
    xfer(1'b1, 2'b01, 8'h10, 16'h5A5A, rd, er);
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      wbase = wr_cnt; rbase = rd_cnt;
      xfer(1'b1, 2'(s), 8'h10, 16'hDEAD, rd, er);
      chk("R7 write err", {15'b0, er, rd}, 32'h0001_0000);
      xfer(1'b0, 2'(s), 8'h12, 16'h0, rd, er);
      chk("R7 read err", {15'b0, er, rd}, 32'h0001_0000);
      chk("R7 no downstream", wr_cnt - wbase + rd_cnt - rbase, 0);
    end
    xfer(1'b1, 2'b01, 8'h12, 16'h7777, rd, er);
    chk("R7 write hold kept", mem[4], 32'h7777_5A5A);
    xfer(1'b0, 2'b01, 8'h2C, 16'h0, rd, er);
    xfer(1'b0, 2'b00, 8'h2E, 16'h0, rd, er);
    xfer(1'b0, 2'b01, 8'h2E, 16'h0, rd, er);
    chk("R7 read hold kept", 32'(rd), 32'(hi_pat(11)));

    // R6
    chk("R6 address bit 1 clear", addr_bad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule